// File: doc/BRIEF.md
# Keyboard Scan-Code Event Decoder

This block sits behind a serial keyboard receiver and turns its byte stream into key events. Each received byte arrives with a valid strobe and a receive error flag. The decoder remembers a key-up prefix (F0) and an extended-key prefix (E0) across bytes. When a plain scan code arrives, it emits one event. The event carries the code, a break (key released) flag and an extended flag, with a one-cycle valid strobe.

The self-test-passed byte (AA), which a keyboard sends when it connects, is not reported as a key. It produces a separate one-cycle status pulse. Prefix bytes produce no output of their own. A byte flagged with a receive error discards any prefix collected so far. Every output is registered, so a result appears exactly one clock after the byte that caused it.

Top module: `kbd_event_decoder`

## Requirements
- R1: After reset, `key_vld` and `selftest_ok` are 0, `key_code`, `key_brk` and `key_ext` are 0, and no prefix is pending.
- R2: A valid, error-free byte that is not E0, F0 or AA, with no prefix pending, gives `key_vld`=1 for one cycle on the next clock, with `key_code` equal to the byte and `key_brk`=0, `key_ext`=0.
- R3: The same code received repeatedly, as happens while a key is held, gives one make event per byte.
- R4: F0 followed by a code gives exactly one event, with `key_brk`=1 and `key_ext`=0. The F0 byte itself gives no event and no status pulse.
- R5: E0 followed by a code gives one event with `key_ext`=1 and `key_brk`=0. The E0 byte itself gives no output.
- R6: E0, then F0, then a code gives one event with `key_brk`=1 and `key_ext`=1.
- R7: Byte AA gives `selftest_ok`=1 for one cycle on the next clock and no key event. It also clears any pending prefix.
- R8: Both prefix flags clear after every emitted event, so the next plain code is reported with `key_brk`=0 and `key_ext`=0.
- R9: A byte with `rx_vld`=1 and `rx_err`=1 produces no output and discards any pending prefix.
- R10: E0 arriving after F0 restarts prefix tracking: the following code is reported with `key_ext`=1 and `key_brk`=0.
- R11: While `rx_vld` is 0, no event and no status pulse are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive error on this byte (framing or parity) |
| key_vld | output | 1 | One-cycle key event strobe |
| key_code | output | 8 | Scan code of the event |
| key_brk | output | 1 | 1 = key released, 0 = key pressed |
| key_ext | output | 1 | 1 = extended key |
| selftest_ok | output | 1 | One-cycle self-test-passed pulse |

## Verification
The only hidden state in this block is the two prefix flags. A wrong flag therefore stays invisible until the next plain code arrives, and then shows as a wrong `key_brk` or `key_ext` on that event, one clock after the byte. The random stream interleaves prefixes, status bytes and error bytes so that stale or missing prefix state is exposed within a few bytes. Directed sequences cover the prefix orderings: F0 then code, E0 then code, E0 F0 code, F0 E0 code, and error between prefix and code.

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder #(
  parameter int W = 8,
  parameter logic [W-1:0] EXT_PFX  = 'hE0,
  parameter logic [W-1:0] BRK_PFX  = 'hF0,
  parameter logic [W-1:0] ST_CODE  = 'hAA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_vld,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_err,
  output logic         key_vld,
  output logic [W-1:0] key_code,
  output logic         key_brk,
  output logic         key_ext,
  output logic         selftest_ok
);

  logic ext_p, brk_p;

  wire good   = rx_vld && !rx_err;
  wire is_ext = rx_byte == EXT_PFX;
  wire is_brk = rx_byte == BRK_PFX;
  wire is_st  = rx_byte == ST_CODE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_p       <= 1'b0;
      brk_p       <= 1'b0;
      key_vld     <= 1'b0;
      key_code    <= '0;
      key_brk     <= 1'b0;
      key_ext     <= 1'b0;
      selftest_ok <= 1'b0;
    end else begin
      key_vld     <= 1'b0;
      selftest_ok <= 1'b0;
      if (rx_vld && rx_err) begin
        ext_p <= 1'b0;
        brk_p <= 1'b0;
      end else if (good) begin
        if (is_ext) begin
          ext_p <= 1'b1;
          brk_p <= 1'b0;
        end else if (is_brk) begin
          brk_p <= 1'b1;
        end else if (is_st) begin
          selftest_ok <= 1'b1;
          ext_p       <= 1'b0;
          brk_p       <= 1'b0;
        end else begin
          key_vld  <= 1'b1;
          key_code <= rx_byte;
          key_brk  <= brk_p;
          key_ext  <= ext_p;
          ext_p    <= 1'b0;
          brk_p    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/kbd_event_decoder_chk.sv
module kbd_event_decoder_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] EXT_PFX  = 'hE0,
  parameter logic [W-1:0] BRK_PFX  = 'hF0,
  parameter logic [W-1:0] ST_CODE  = 'hAA
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_vld,
  input logic [W-1:0] rx_byte,
  input logic         rx_err,
  input logic         key_vld,
  input logic [W-1:0] key_code,
  input logic         key_brk,
  input logic         key_ext,
  input logic         selftest_ok
);

  AST_CODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |-> ($past(rx_vld) && !$past(rx_err) && key_code == $past(rx_byte))); // R2

  AST_PFX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !rx_err && (rx_byte == EXT_PFX || rx_byte == BRK_PFX)) |=> (!key_vld && !selftest_ok)); // R4

  AST_ST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_ok |-> ($past(rx_vld) && $past(rx_byte) == ST_CODE)); // R7

  AST_ST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_vld && selftest_ok)); // R7

  AST_BACK_TO_BACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && $past(key_vld)) |-> (!key_brk && !key_ext)); // R8

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_err) |=> (!key_vld && !selftest_ok)); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> (!key_vld && !selftest_ok)); // R11

endmodule

bind kbd_event_decoder kbd_event_decoder_chk #(
  .W(W), .EXT_PFX(EXT_PFX), .BRK_PFX(BRK_PFX), .ST_CODE(ST_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_err(rx_err),
  .key_vld(key_vld), .key_code(key_code), .key_brk(key_brk), .key_ext(key_ext),
  .selftest_ok(selftest_ok)
);

// File: tb/tb_kbd_event_decoder.sv
module tb_kbd_event_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_vld = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_err = 1'b0;
  logic       key_vld, key_brk, key_ext, selftest_ok;
  logic [7:0] key_code;

  int n_chk = 0;
  int n_bad = 0;
  bit m_ext = 0;
  bit m_brk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_event_decoder dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_err(rx_err),
    .key_vld(key_vld), .key_code(key_code), .key_brk(key_brk), .key_ext(key_ext),
    .selftest_ok(selftest_ok)
  );

  // expected {vld, code, brk, ext, st}; updates the model prefix state
  function automatic logic [11:0] model(input logic [7:0] b, input logic err);
    logic [11:0] r;
    r = '0;
    if (err) begin
      m_ext = 0; m_brk = 0;
    end else if (b == 8'hE0) begin
      m_ext = 1; m_brk = 0;
    end else if (b == 8'hF0) begin
      m_brk = 1;
    end else if (b == 8'hAA) begin
      r[0] = 1'b1; m_ext = 0; m_brk = 0;
    end else begin
      r = {1'b1, b, m_brk, m_ext, 1'b0};
      m_ext = 0; m_brk = 0;
    end
    return r;
  endfunction

  task automatic compare(input string tag, input logic [11:0] exp);
    logic [11:0] act;
    act = {key_vld, key_code, key_brk, key_ext, selftest_ok};
    if (!exp[11]) begin
      act[10:1] = '0;
    end
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: vld/code/brk/ext/st actual %b_%h_%b%b_%b expected %b_%h_%b%b_%b",
               tag, act[11], act[10:3], act[2], act[1], act[0],
               exp[11], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic send(input string tag, input logic [7:0] b, input logic err);
    logic [11:0] exp;
    @(negedge clk);
    rx_vld = 1'b1; rx_byte = b; rx_err = err;
    exp = model(b, err);
    @(negedge clk);
    rx_vld = 1'b0; rx_err = 1'b0;
    compare(tag, exp);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    rx_byte = 8'hE0;
    @(negedge clk);
    compare(tag, 12'h000);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if ({key_vld, key_code, key_brk, key_ext, selftest_ok} !== 12'h000) begin
      n_bad++;
      $display("FAIL R1: actual %b%h%b%b%b expected 0", key_vld, key_code, key_brk, key_ext, selftest_ok);
    end
    rst_n = 1'b1;
    send("R1_no_prefix", 8'h1C, 1'b0);
    send("R2", 8'h12, 1'b0);
    send("R3_a", 8'h59, 1'b0);
    send("R3_b", 8'h59, 1'b0);
    send("R3_c", 8'h59, 1'b0);
    send("R4_pfx", 8'hF0, 1'b0);
    send("R4", 8'h14, 1'b0);
    send("R5_pfx", 8'hE0, 1'b0);
    send("R5", 8'h14, 1'b0);
    send("R6_e0", 8'hE0, 1'b0);
    send("R6_f0", 8'hF0, 1'b0);
    send("R6", 8'h14, 1'b0);
    send("R8", 8'h33, 1'b0);
    send("R7_pfx", 8'hF0, 1'b0);
    send("R7", 8'hAA, 1'b0);
    send("R7_clear", 8'h1B, 1'b0);
    send("R9_pfx", 8'hE0, 1'b0);
    send("R9_f0", 8'hF0, 1'b0);
    send("R9", 8'h2D, 1'b1);
    send("R9_fresh", 8'h2D, 1'b0);
    send("R10_f0", 8'hF0, 1'b0);
    send("R10_e0", 8'hE0, 1'b0);
    send("R10", 8'h11, 1'b0);
    send("R11_pfx", 8'hF0, 1'b0);
    idle_check("R11");
    send("R11_after", 8'h24, 1'b0);
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      logic [7:0] b;
      logic e;
      k = $urandom % 10;
      e = 1'b0;
      b = 8'($urandom);
      if (k < 2) b = 8'hE0;
      else if (k < 4) b = 8'hF0;
      else if (k == 4) b = 8'hAA;
      else if (k == 5) e = 1'b1;
      else if (b == 8'hE0 || b == 8'hF0 || b == 8'hAA) b = 8'h29;
      send("R8_rand", b, e);
      if (($urandom % 8) == 0) idle_check("R11_rand");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule